// File: doc/BRIEF.md
# PLL power-up sequencing controller

This block drives the control word of a fractional PLL so that its analog stages come up and go down in a safe order. In direct mode, a power-up request first releases bypass. After a fixed settling time it releases reset. It then samples the readiness input once per microsecond, up to a bounded number of samples, and opens the output gate only when readiness is seen. A power-down request closes the output gate first. After a short drain it drops reset and bypass in the same cycle.

A hardware-vote mode, selected through a configuration bit of the control word, skips the analog sequence. In that mode a power-up request raises a vote line and waits for the active flag, and a power-down request simply withdraws the vote. If the readiness sample limit passes without success, a sticky timeout flag is set and the output stays closed. The next accepted power-up request clears the flag. Microsecond timing comes from a prescaler sized by the reference-clock parameter.

Software reads the whole control word through one read port and writes its configuration fields through one write port. A power-up or power-down request is a one-cycle pulse, and the request handshake reports `seq_busy` while a sequence runs and a one-cycle `seq_done` when it ends.

The sequencer has five states:

- `ST_IDLE`: waits for a request.
- `ST_BYP_SETTLE`: bypass is released and the settling time runs.
- `ST_LOCK_POLL`: reset is released and lock is sampled.
- `ST_OUT_DRAIN`: the output is closed and the drain time runs.
- `ST_VOTE_POLL`: the vote is raised and the active flag is sampled.

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| start | `ST_IDLE` | `ST_BYP_SETTLE` | power-up request, direct mode, not already fully on |
| already-on | `ST_IDLE` | `ST_IDLE` | power-up request while all three control bits are set |
| vote-on | `ST_IDLE` | `ST_VOTE_POLL` | power-up request in vote mode |
| vote-off | `ST_IDLE` | `ST_IDLE` | power-down request in vote mode |
| drain | `ST_IDLE` | `ST_OUT_DRAIN` | power-down request in direct mode |
| settle-done | `ST_BYP_SETTLE` | `ST_LOCK_POLL` | settling time has elapsed |
| lock-ok | `ST_LOCK_POLL` | `ST_IDLE` | a lock sample is high |
| vote-ready | `ST_VOTE_POLL` | `ST_IDLE` | an active-flag sample is high |
| expire | either poll state | `ST_IDLE` | the last sample is low |
| drain-done | `ST_OUT_DRAIN` | `ST_IDLE` | drain time has elapsed |

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset all control outputs (`pll_outen`, `pll_bypass_n`, `pll_reset_n`, `pll_vote`) are 0, the configuration fields are 0, and `seq_busy`, `seq_done` and `seq_timeout` are 0.
- R2: The control word read on `reg_rd_data` has the following layout:
  - bit 0: output gate.
  - bit 1: bypass release.
  - bit 2: reset release.
  - bits 13:8: lock count.
  - bits 19:14: bias count.
  - bit 20: vote-mode enable.
  - bit 21: vote reset.
  - bit 23: vote line.
  - bit 29: timeout flag.
  - bit 30: active input.
  - bit 31: lock input.
  - all other bits: 0.

  A write stores only bits 21:8, which appear on `reg_rd_data` and on the matching pins one cycle later. Written values of bits 0 to 2 have no effect on the control outputs.
- R3: In direct mode, a power-up request sets `pll_bypass_n` at the edge that samples it. `pll_reset_n` rises exactly BYP_GAP_US*CYC_PER_US cycles later.
- R4: After reset release, lock is sampled every CYC_PER_US cycles. The first high sample sets `pll_outen` and ends the sequence.
- R5: If POLL_MAX consecutive samples are all low, `seq_timeout` is set, `seq_done` pulses and `pll_outen` stays 0.
- R6: A direct-mode power-up request while output, bypass release and reset release are all set completes at once (`seq_done` in the next cycle) with no change to the control outputs.
- R7: In direct mode, a power-down request clears `pll_outen` at its sampling edge. `pll_reset_n` and `pll_bypass_n` fall together exactly OFF_GAP_US*CYC_PER_US cycles later.
- R8: In vote mode, a power-up request only raises `pll_vote` and samples the active flag, ignoring lock. The same sample limit and timeout rule as R5 applies.
- R9: In vote mode, a power-down request only clears `pll_vote` and completes at once. The other control bits are unchanged.
- R10: Requests arriving while `seq_busy` is high are ignored. When both requests arrive together in idle, power-up takes priority.
- R11: The timeout flag stays set until the next accepted power-up request, which clears it at its sampling edge.
- R12: `seq_done` is a one-cycle pulse in the cycle after the completing edge, with `seq_busy` low. `seq_busy` is high from the cycle after an accepted sequenced request until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control-word write strobe |
| reg_wr_data | input | 32 | Control-word write value |
| reg_rd_data | output | 32 | Control-word read value |
| seq_on_req | input | 1 | Power-up request pulse |
| seq_off_req | input | 1 | Power-down request pulse |
| seq_busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle completion pulse |
| seq_timeout | output | 1 | Sticky readiness timeout flag |
| pll_lock | input | 1 | Lock detect from the PLL |
| pll_active | input | 1 | Active flag from the PLL |
| pll_outen | output | 1 | Output gate enable |
| pll_bypass_n | output | 1 | Bypass release (active-low bypass) |
| pll_reset_n | output | 1 | Reset release (active-low reset) |
| pll_vote | output | 1 | Hardware vote line |
| pll_lock_cnt | output | 6 | Lock count field |
| pll_bias_cnt | output | 6 | Bias count field |
| pll_vote_rst | output | 1 | Vote reset field |

## Verification
The bound assertions check on every cycle the ordering properties that hold at any instant:

- the output gate is open only with reset and bypass released;
- reset rises only after the full settling window with bypass released;
- reset and bypass fall together, only after the drain window with the gate closed;
- the gate opens only on a high lock sample;
- a timeout never coincides with an open gate;
- the vote rises only in vote mode;
- `seq_done` never comes with `seq_busy`.

Exact cycle counts, request priority, ignored requests during a sequence, sticky-flag clearing and the write masking of the control word depend on stimulus history. Only the bench's scenarios show these, by comparing every output against its behavioural model.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int WORD_W   = 32;
    localparam int FIELD_W  = 6;

    // Control word bit positions (R2)
    localparam int B_OUT    = 0;
    localparam int B_BYP    = 1;
    localparam int B_RST    = 2;
    localparam int LCNT_LSB = 8;
    localparam int BCNT_LSB = LCNT_LSB + FIELD_W;
    localparam int B_VEN    = BCNT_LSB + FIELD_W;
    localparam int B_VRST   = B_VEN + 1;
    localparam int B_VOTE   = 23;
    localparam int B_TO     = 29;
    localparam int B_ACT    = 30;
    localparam int B_LOCK   = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BYP_SETTLE,
        ST_LOCK_POLL,
        ST_OUT_DRAIN,
        ST_VOTE_POLL
    } seq_state_e;

    // Writable configuration fields, packed in word order (bits 21:8)
    typedef struct packed {
        logic               vote_rst;
        logic               vote_en;
        logic [FIELD_W-1:0] bias_cnt;
        logic [FIELD_W-1:0] lock_cnt;
    } mode_cfg_t;

    typedef struct packed {
        logic vote;
        logic rst_rel;
        logic byp_rel;
        logic out_en;
    } pll_ctrl_t;

endpackage

// File: rtl/pll_us_timer.sv
module pll_us_timer #(
    parameter int CYC_PER_US = 200,
    parameter int US_W       = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic            tick,
    output logic [US_W-1:0] us_cnt
);

    localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);
    localparam logic [US_W-1:0]  US_SAT   = '1;

    logic [PRE_W-1:0] pre_q;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us_cnt <= '0;
        end else if (clr) begin
            us_cnt <= '0;
        end else if (tick && us_cnt != US_SAT) begin
            us_cnt <= us_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pll_mode_reg.sv
module pll_mode_reg
    import pll_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  pll_ctrl_t         ctrl,
    input  logic              timeout,
    input  logic              lock_in,
    input  logic              active_in,
    output mode_cfg_t         cfg,
    output logic [WORD_W-1:0] rd_data
);

    // R2: only the configuration bits are stored; control bits are sequencer-owned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg <= wr_data[B_VRST:LCNT_LSB];
        end
    end

    always_comb begin
        rd_data                  = '0;
        rd_data[B_OUT]           = ctrl.out_en;
        rd_data[B_BYP]           = ctrl.byp_rel;
        rd_data[B_RST]           = ctrl.rst_rel;
        rd_data[B_VRST:LCNT_LSB] = cfg;
        rd_data[B_VOTE]          = ctrl.vote;
        rd_data[B_TO]            = timeout;
        rd_data[B_ACT]           = active_in;
        rd_data[B_LOCK]          = lock_in;
    end

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int BYP_GAP_US = 5,
    parameter int OFF_GAP_US = 1,
    parameter int POLL_MAX   = 100,
    parameter int US_W       = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_on,
    input  logic            req_off,
    input  logic            vote_en,
    input  logic            lock_in,
    input  logic            active_in,
    input  logic            tick,
    input  logic [US_W-1:0] us_cnt,
    output logic            tmr_clr,
    output pll_ctrl_t       ctrl,
    output logic            busy,
    output logic            done,
    output logic            timeout
);

    localparam logic [US_W-1:0] BYP_LAST  = US_W'(BYP_GAP_US - 1);
    localparam logic [US_W-1:0] OFF_LAST  = US_W'(OFF_GAP_US - 1);
    localparam logic [US_W-1:0] POLL_LAST = US_W'(POLL_MAX - 1);

    seq_state_e state_q, state_d;

    logic ev_start, ev_already_on, ev_vote_on, ev_vote_off, ev_drain;
    logic ev_rst_rel, ev_lock_ok, ev_vote_ready, ev_expire, ev_off_done;
    logic all_on;

    assign all_on = ctrl.out_en && ctrl.byp_rel && ctrl.rst_rel;

    // Next state and transition events
    always_comb begin
        state_d       = state_q;
        ev_start      = 1'b0;
        ev_already_on = 1'b0;
        ev_vote_on    = 1'b0;
        ev_vote_off   = 1'b0;
        ev_drain      = 1'b0;
        ev_rst_rel    = 1'b0;
        ev_lock_ok    = 1'b0;
        ev_vote_ready = 1'b0;
        ev_expire     = 1'b0;
        ev_off_done   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_on) begin                     // R10: power-up wins
                    if (vote_en) begin
                        ev_vote_on = 1'b1;            // R8
                        state_d    = ST_VOTE_POLL;
                    end else if (all_on) begin
                        ev_already_on = 1'b1;         // R6
                    end else begin
                        ev_start = 1'b1;              // R3
                        state_d  = ST_BYP_SETTLE;
                    end
                end else if (req_off) begin
                    if (vote_en) begin
                        ev_vote_off = 1'b1;           // R9
                    end else begin
                        ev_drain = 1'b1;              // R7
                        state_d  = ST_OUT_DRAIN;
                    end
                end
            end
            ST_BYP_SETTLE: begin
                if (tick && us_cnt == BYP_LAST) begin
                    ev_rst_rel = 1'b1;
                    state_d    = ST_LOCK_POLL;
                end
            end
            ST_LOCK_POLL: begin
                if (tick) begin
                    if (lock_in) begin                // R4
                        ev_lock_ok = 1'b1;
                        state_d    = ST_IDLE;
                    end else if (us_cnt == POLL_LAST) begin
                        ev_expire = 1'b1;             // R5
                        state_d   = ST_IDLE;
                    end
                end
            end
            ST_OUT_DRAIN: begin
                if (tick && us_cnt == OFF_LAST) begin
                    ev_off_done = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            ST_VOTE_POLL: begin
                if (tick) begin
                    if (active_in) begin
                        ev_vote_ready = 1'b1;
                        state_d       = ST_IDLE;
                    end else if (us_cnt == POLL_LAST) begin
                        ev_expire = 1'b1;
                        state_d   = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign tmr_clr = (state_d != state_q);
    assign busy    = (state_q != ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            done <= 1'b0;                             // R12: single-cycle pulse
            if (ev_start) begin
                ctrl.byp_rel <= 1'b1;
                timeout      <= 1'b0;                 // R11
            end
            if (ev_already_on) begin
                done    <= 1'b1;
                timeout <= 1'b0;
            end
            if (ev_vote_on) begin
                ctrl.vote <= 1'b1;
                timeout   <= 1'b0;
            end
            if (ev_vote_off) begin
                ctrl.vote <= 1'b0;
                done      <= 1'b1;
            end
            if (ev_drain) begin
                ctrl.out_en <= 1'b0;
            end
            if (ev_rst_rel) begin
                ctrl.rst_rel <= 1'b1;
            end
            if (ev_lock_ok) begin
                ctrl.out_en <= 1'b1;
                done        <= 1'b1;
            end
            if (ev_vote_ready) begin
                done <= 1'b1;
            end
            if (ev_expire) begin
                timeout <= 1'b1;
                done    <= 1'b1;
            end
            if (ev_off_done) begin
                ctrl.rst_rel <= 1'b0;
                ctrl.byp_rel <= 1'b0;
                done         <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter int CYC_PER_US = 200,
    parameter int BYP_GAP_US = 5,
    parameter int OFF_GAP_US = 1,
    parameter int POLL_MAX   = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    input  logic        seq_on_req,
    input  logic        seq_off_req,
    output logic        seq_busy,
    output logic        seq_done,
    output logic        seq_timeout,
    input  logic        pll_lock,
    input  logic        pll_active,
    output logic        pll_outen,
    output logic        pll_bypass_n,
    output logic        pll_reset_n,
    output logic        pll_vote,
    output logic [5:0]  pll_lock_cnt,
    output logic [5:0]  pll_bias_cnt,
    output logic        pll_vote_rst
);

    localparam int MAX_GAP = (BYP_GAP_US > OFF_GAP_US) ? BYP_GAP_US : OFF_GAP_US;
    localparam int MAX_US  = (POLL_MAX > MAX_GAP) ? POLL_MAX : MAX_GAP;
    localparam int US_W    = $clog2(MAX_US + 1);

    mode_cfg_t       cfg_q;
    pll_ctrl_t       ctrl;
    logic            tmr_clr;
    logic            tick;
    logic [US_W-1:0] us_cnt;

    pll_us_timer #(
        .CYC_PER_US (CYC_PER_US),
        .US_W       (US_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .tick   (tick),
        .us_cnt (us_cnt)
    );

    pll_seq_fsm #(
        .BYP_GAP_US (BYP_GAP_US),
        .OFF_GAP_US (OFF_GAP_US),
        .POLL_MAX   (POLL_MAX),
        .US_W       (US_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_on    (seq_on_req),
        .req_off   (seq_off_req),
        .vote_en   (cfg_q.vote_en),
        .lock_in   (pll_lock),
        .active_in (pll_active),
        .tick      (tick),
        .us_cnt    (us_cnt),
        .tmr_clr   (tmr_clr),
        .ctrl      (ctrl),
        .busy      (seq_busy),
        .done      (seq_done),
        .timeout   (seq_timeout)
    );

    pll_mode_reg u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .ctrl      (ctrl),
        .timeout   (seq_timeout),
        .lock_in   (pll_lock),
        .active_in (pll_active),
        .cfg       (cfg_q),
        .rd_data   (reg_rd_data)
    );

    assign pll_outen    = ctrl.out_en;
    assign pll_bypass_n = ctrl.byp_rel;
    assign pll_reset_n  = ctrl.rst_rel;
    assign pll_vote     = ctrl.vote;
    assign pll_lock_cnt = cfg_q.lock_cnt;
    assign pll_bias_cnt = cfg_q.bias_cnt;
    assign pll_vote_rst = cfg_q.vote_rst;

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
    parameter int CYC_PER_US = 200,
    parameter int BYP_GAP_US = 5,
    parameter int OFF_GAP_US = 1
) (
    input logic clk,
    input logic rst_n,
    input logic pll_outen,
    input logic pll_bypass_n,
    input logic pll_reset_n,
    input logic pll_vote,
    input logic pll_lock,
    input logic vote_en,
    input logic seq_busy,
    input logic seq_done,
    input logic seq_timeout
);

    localparam logic [31:0] BYP_CYC = 32'(BYP_GAP_US * CYC_PER_US);
    localparam logic [31:0] OFF_CYC = 32'(OFF_GAP_US * CYC_PER_US);

    logic [31:0] byp_cnt;
    logic [31:0] off_cnt;

    // Cycles spent with bypass released but reset still held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byp_cnt <= '0;
        end else if (!pll_bypass_n) begin
            byp_cnt <= '0;
        end else if (!pll_reset_n && byp_cnt != '1) begin
            byp_cnt <= byp_cnt + 1'b1;
        end
    end

    // Cycles spent with the output closed but reset still released
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_cnt <= '0;
        end else if (pll_outen) begin
            off_cnt <= '0;
        end else if (pll_reset_n && off_cnt != '1) begin
            off_cnt <= off_cnt + 1'b1;
        end
    end

    assert_out_needs_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pll_outen |-> (pll_reset_n && pll_bypass_n));

    assert_reset_after_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_reset_n) |-> $past(pll_bypass_n));

    assert_settle_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_reset_n) |-> (byp_cnt >= BYP_CYC));

    assert_gate_on_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_outen) |-> $past(pll_lock));

    assert_timeout_gate_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_timeout) |-> !pll_outen);

    assert_release_drop_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_reset_n) |-> ($fell(pll_bypass_n) && !$past(pll_outen)));

    assert_drain_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_reset_n) |-> (off_cnt >= OFF_CYC));

    assert_vote_only_in_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_vote) |-> $past(vote_en));

    assert_done_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !seq_busy);

endmodule

bind pll_seq_ctrl pll_seq_chk #(
    .CYC_PER_US (CYC_PER_US),
    .BYP_GAP_US (BYP_GAP_US),
    .OFF_GAP_US (OFF_GAP_US)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pll_outen    (pll_outen),
    .pll_bypass_n (pll_bypass_n),
    .pll_reset_n  (pll_reset_n),
    .pll_vote     (pll_vote),
    .pll_lock     (pll_lock),
    .vote_en      (cfg_q.vote_en),
    .seq_busy     (seq_busy),
    .seq_done     (seq_done),
    .seq_timeout  (seq_timeout)
);

// File: tb/tb_pll_seq_ctrl.sv
`timescale 1ns/100ps
module tb_pll_seq_ctrl;

    localparam int C   = 4;
    localparam int GAP = 5;
    localparam int OFF = 1;
    localparam int LIM = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        seq_on_req = 1'b0;
    logic        seq_off_req = 1'b0;
    logic        seq_busy, seq_done, seq_timeout;
    logic        pll_lock = 1'b0;
    logic        pll_active = 1'b0;
    logic        pll_outen, pll_bypass_n, pll_reset_n, pll_vote, pll_vote_rst;
    logic [5:0]  pll_lock_cnt, pll_bias_cnt;

    int vectors = 0;
    int miscompares = 0;
    bit chk_on = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pll_seq_ctrl #(
        .CYC_PER_US (C),
        .BYP_GAP_US (GAP),
        .OFF_GAP_US (OFF),
        .POLL_MAX   (LIM)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .reg_wr_en (reg_wr_en), .reg_wr_data (reg_wr_data), .reg_rd_data (reg_rd_data),
        .seq_on_req (seq_on_req), .seq_off_req (seq_off_req),
        .seq_busy (seq_busy), .seq_done (seq_done), .seq_timeout (seq_timeout),
        .pll_lock (pll_lock), .pll_active (pll_active),
        .pll_outen (pll_outen), .pll_bypass_n (pll_bypass_n), .pll_reset_n (pll_reset_n),
        .pll_vote (pll_vote), .pll_lock_cnt (pll_lock_cnt), .pll_bias_cnt (pll_bias_cnt),
        .pll_vote_rst (pll_vote_rst)
    );

    // Behavioural reference model: phase 0 idle, 1 settle, 2 lock poll, 3 drain, 4 vote poll
    int         m_ph, m_cnt;
    bit         m_out, m_byp, m_rst, m_vote, m_done, m_to;
    logic [13:0] m_cfg;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_out = 0; m_byp = 0; m_rst = 0;
            m_vote = 0; m_done = 0; m_to = 0; m_cfg = '0;
        end else begin
            m_done = 0;
            case (m_ph)
                0: begin
                    if (seq_on_req) begin
                        m_to = 0;
                        if (m_cfg[12]) begin
                            m_vote = 1; m_ph = 4; m_cnt = 0;
                        end else if (m_out && m_byp && m_rst) begin
                            m_done = 1;
                        end else begin
                            m_byp = 1; m_ph = 1; m_cnt = 0;
                        end
                    end else if (seq_off_req) begin
                        if (m_cfg[12]) begin
                            m_vote = 0; m_done = 1;
                        end else begin
                            m_out = 0; m_ph = 3; m_cnt = 0;
                        end
                    end
                end
                1: begin
                    m_cnt++;
                    if (m_cnt == GAP * C) begin
                        m_rst = 1; m_ph = 2; m_cnt = 0;
                    end
                end
                2, 4: begin
                    bit ready;
                    ready = (m_ph == 2) ? pll_lock : pll_active;
                    m_cnt++;
                    if (m_cnt % C == 0) begin
                        if (ready) begin
                            if (m_ph == 2) m_out = 1;
                            m_done = 1; m_ph = 0;
                        end else if (m_cnt == LIM * C) begin
                            m_to = 1; m_done = 1; m_ph = 0;
                        end
                    end
                end
                3: begin
                    m_cnt++;
                    if (m_cnt == OFF * C) begin
                        m_rst = 0; m_byp = 0; m_done = 1; m_ph = 0;
                    end
                end
                default: m_ph = 0;
            endcase
            if (reg_wr_en) m_cfg = reg_wr_data[21:8];
        end
    end

    function automatic logic [31:0] exp_word();
        return {pll_lock, pll_active, m_to, 5'b0, m_vote, 1'b0, m_cfg, 5'b0, m_rst, m_byp, m_out};
    endfunction

    // Whole-output comparison once per cycle, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            logic [56:0] got, exp;
            got = {reg_rd_data, pll_outen, pll_bypass_n, pll_reset_n, pll_vote,
                   pll_lock_cnt, pll_bias_cnt, pll_vote_rst, seq_busy, seq_done, seq_timeout};
            exp = {exp_word(), m_out, m_byp, m_rst, m_vote,
                   m_cfg[5:0], m_cfg[11:6], m_cfg[13], (m_ph != 0), m_done, m_to};
            vectors++;
            if (got !== exp) begin
                miscompares++;
                $display("FAIL %s model compare at %0t: got %h expected %h", cur_req, $time, got, exp);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic pulse_on();
        seq_on_req = 1'b1; step(1); seq_on_req = 1'b0;
    endtask

    task automatic pulse_off();
        seq_off_req = 1'b1; step(1); seq_off_req = 1'b0;
    endtask

    task automatic write_word(input logic [31:0] v);
        reg_wr_data = v; reg_wr_en = 1'b1; step(1); reg_wr_en = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (!seq_done && n < 2000) begin
            step(1);
            n++;
        end
        check(tag, {31'b0, seq_done}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int n;
        step(3);
        rst_n = 1'b1;
        chk_on = 1'b1;
        step(1);

        // R1: reset state
        cur_req = "R1";
        check("R1 word", reg_rd_data, 32'h0);
        check("R1 status", {29'b0, seq_busy, seq_done, seq_timeout}, 32'h0);

        // R2: only bits 21:8 are stored, control bits unaffected
        cur_req = "R2";
        write_word(32'h001F_FFFF);
        check("R2 word", reg_rd_data, 32'h001F_FF00);
        check("R2 ignored ctrl", {29'b0, pll_outen, pll_bypass_n, pll_reset_n}, 32'h0);
        write_word(32'h002F_3A07);
        check("R2 lock cnt", {26'b0, pll_lock_cnt}, {26'b0, 6'(32'h002F_3A07 >> 8)});
        check("R2 bias cnt", {26'b0, pll_bias_cnt}, {26'b0, 6'(32'h002F_3A07 >> 14)});
        check("R2 vote rst", {31'b0, pll_vote_rst}, 32'd1);

        // R3 / R4: direct power-up, lock after two samples
        cur_req = "R3";
        pll_lock = 1'b0;
        pulse_on();
        check("R3 bypass first", {30'b0, pll_bypass_n, pll_reset_n}, 32'h2);
        n = 0;
        while (!pll_reset_n && n < 1000) begin
            step(1);
            n++;
        end
        check("R3 settle cycles", n, GAP * C);
        cur_req = "R4";
        step(C + 2);
        check("R4 no gate before lock", {31'b0, pll_outen}, 32'd0);
        pll_lock = 1'b1;
        wait_done("R4 done");
        check("R4 gate open", {31'b0, pll_outen}, 32'd1);

        // R6 / R12: already-on request completes at once
        cur_req = "R6";
        pulse_on();
        check("R6 immediate done", {30'b0, seq_done, seq_busy}, 32'h2);
        cur_req = "R12";
        step(1);
        check("R12 single pulse", {31'b0, seq_done}, 32'd0);

        // R10: simultaneous requests, power-up wins (already on)
        cur_req = "R10";
        seq_on_req = 1'b1; seq_off_req = 1'b1; step(1);
        seq_on_req = 1'b0; seq_off_req = 1'b0;
        check("R10 priority", {30'b0, pll_outen, seq_done}, 32'h3);

        // R7: power-down with drain window
        cur_req = "R7";
        pulse_off();
        check("R7 gate closed first", {29'b0, pll_outen, pll_bypass_n, pll_reset_n}, 32'h3);
        n = 0;
        while (pll_reset_n && n < 1000) begin
            step(1);
            n++;
        end
        check("R7 drain cycles", n, OFF * C);
        check("R7 bypass with reset", {31'b0, pll_bypass_n}, 32'd0);

        // R10: power-up during drain is ignored
        cur_req = "R10";
        pulse_on();
        wait_done("R10 up");
        pulse_off();
        pulse_on();
        wait_done("R10 drain");
        step(1);
        check("R10 ignored up", {28'b0, seq_busy, pll_outen, pll_bypass_n, pll_reset_n}, 32'h0);

        // R5: timeout
        cur_req = "R5";
        pll_lock = 1'b0;
        pulse_on();
        wait_done("R5 done");
        check("R5 flag", {30'b0, seq_timeout, pll_outen}, 32'h2);
        step(5);
        check("R11 sticky", {31'b0, seq_timeout}, 32'd1);

        // R11: next power-up clears the flag
        cur_req = "R11";
        pll_lock = 1'b1;
        pulse_on();
        check("R11 cleared", {31'b0, seq_timeout}, 32'd0);
        wait_done("R11 done");
        pulse_off();
        wait_done("R11 off");

        // R8: vote mode ignores lock, waits for active
        cur_req = "R8";
        write_word(32'h0010_0000);
        pulse_on();
        check("R8 vote raised", {30'b0, pll_vote, pll_bypass_n}, 32'h2);
        step(3 * C);
        check("R8 lock ignored", {30'b0, seq_busy, pll_outen}, 32'h2);
        pll_active = 1'b1;
        wait_done("R8 active");

        // R9: vote withdraw
        cur_req = "R9";
        pulse_off();
        check("R9 withdraw", {28'b0, pll_vote, seq_done, pll_bypass_n, pll_reset_n}, 32'h4);

        // R8: vote-mode timeout
        cur_req = "R8";
        pll_active = 1'b0;
        pulse_on();
        wait_done("R8 timeout done");
        check("R8 timeout flag", {31'b0, seq_timeout}, 32'd1);

        step(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule